// File: doc/BRIEF.md
# Flash Byte Program Sequencer

This block writes a run of bytes into a byte-wide flash that needs a closed-loop program algorithm. It sits on the host side. It takes a start address and a byte count on a start pulse. It pulls the bytes to be written from a valid/ready source stream. It reaches the flash through a simple bus-master request port, where a request is held until the flash side acknowledges it.

For every byte, the block makes one or more attempts. Each attempt has these steps:
- write the setup command 40h;
- write the data byte to its target address, which starts a timed program pulse;
- wait out the pulse;
- write the verify command C0h;
- wait for the margin read to settle;
- read the byte back and compare it with the expected data.

A mismatch starts a new attempt, up to a parameterized limit per byte. The attempt count restarts for each new byte. When the run ends, whether it passed or failed, the block writes the read command 00h, drops its high-voltage enable and pulses `done`. A failure raises `fail` and reports the address of the byte that failed.

The wait lengths are parameters counted in clock cycles. The parameter defaults give 10 µs and 6 µs at 100 MHz.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, and while idle, `hvEnable`, `busReq`, `srcReady`, `done` and `fail` are all low.
- R2: Each attempt is a write of 40h followed directly by a write of the data byte to the byte's target address (`busWe`=1 for writes, 0 for reads).
- R3: At least `PULSE_CYC` cycles pass between the acknowledge of the data write and the request of the verify command C0h.
- R4: At least `VERIFY_CYC` cycles pass between the acknowledge of C0h and the read request, and the read goes to the byte's target address.
- R5: A byte whose read-back first matches on attempt k, with k ≤ `MAX_TRIES`, receives exactly k program pulses. The run then continues with the next byte.
- R6: A byte that still mismatches after `MAX_TRIES` pulses ends the run with `fail`=1. No byte after it is programmed, and no byte sees more than `MAX_TRIES` pulses.
- R7: Bytes are taken from the source stream in order and written to consecutive ascending addresses from `startAddr`. The attempt count restarts at zero for each byte.
- R8: Every run ends with a single write of 00h. Then, in the same cycle, `done` pulses for one cycle and `hvEnable` goes low. `fail` only rises together with `done`.
- R9: While `fail` is high, `failAddr` holds the address of the failing byte. Otherwise it is zero. The next start clears `fail`.
- R10: A start with `byteCount`=0 programs nothing, writes only 00h and completes with `fail`=0.
- R11: A bus request holds its address, data and direction stable until acknowledged, and `hvEnable` is high whenever `busReq` is high.
- R12: `srcReady` is high only while no bus request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken while idle |
| startAddr | input | ADDR_W | Address of the first byte |
| byteCount | input | CNT_W | Number of bytes to program |
| srcValid | input | 1 | Source byte valid |
| srcData | input | 8 | Source byte |
| srcReady | output | 1 | Block accepts a source byte |
| busReq | output | 1 | Bus request, held until acknowledged |
| busWe | output | 1 | 1 = write, 0 = read |
| busAddr | output | ADDR_W | Bus address |
| busWdata | output | 8 | Write data or command byte |
| busAck | input | 1 | One-cycle acknowledge; read data valid with it |
| busRdata | input | 8 | Read data |
| hvEnable | output | 1 | Program voltage enable, high during a run |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Run ended in failure; held until next start |
| failAddr | output | ADDR_W | Failing byte address while `fail` is high |

## Verification
The checker watches the bus protocol on every cycle. It checks that requests are held until acknowledged and that `hvEnable` is high whenever a request is up. It also enforces the minimum pulse and verify gaps, measured from the command stream itself, and the per-byte attempt limit. Finally, it checks that the source stream and the bus stay exclusive and that `fail` and `done` appear together.

Other properties can only be shown by the bench scenarios, which run against a flash model that needs a chosen number of pulses per address:
- the exact number of pulses each byte receives;
- that the stored contents match the source stream;
- the failing address;
- that later bytes stay untouched after a failure;
- the zero-count run.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

  localparam logic [7:0] CMD_SETUP  = 8'h40;
  localparam logic [7:0] CMD_VERIFY = 8'hC0;
  localparam logic [7:0] CMD_READ   = 8'h00;

  typedef enum logic [3:0] {
    S_IDLE,
    S_FETCH,
    S_SETUP,
    S_LOAD,
    S_PULSE,
    S_VCMD,
    S_VWAIT,
    S_READ,
    S_FINISH
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStart;
    logic loadByte;
    logic advance;
    logic bumpTry;
    logic armPulse;
    logic armVerify;
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic timerZero;
    logic lastByte;
    logic noBytes;
    logic triesSpent;
    logic readMatch;
  } dpStat_t;

endpackage

// File: rtl/flash_prog_dpath.sv
module flash_prog_dpath
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int CNT_W      = ADDR_W + 1,
  parameter int PULSE_CYC  = 1000,
  parameter int VERIFY_CYC = 600,
  parameter int MAX_TRIES  = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [7:0]        srcData,
  input  logic [7:0]        busRdata,
  output dpStat_t           stat,
  output logic [ADDR_W-1:0] curAddr,
  output logic [7:0]        curData
);

  localparam int TMR_TOP = (PULSE_CYC > VERIFY_CYC) ? PULSE_CYC : VERIFY_CYC;
  localparam int TMR_W   = $clog2(TMR_TOP + 1);
  localparam int TRY_W   = $clog2(MAX_TRIES + 1);

  logic [CNT_W-1:0] remaining;
  logic [TMR_W-1:0] timer;
  logic [TRY_W-1:0] tries;

  // address and remaining-byte count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      remaining <= '0;
    end else if (ctrl.loadStart) begin
      curAddr   <= startAddr;
      remaining <= byteCount;
    end else if (ctrl.advance) begin
      curAddr   <= curAddr + 1'b1;
      remaining <= remaining - 1'b1;
    end
  end

  // expected byte and per-byte attempt count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curData <= '0;
      tries   <= '0;
    end else if (ctrl.loadByte) begin
      curData <= srcData;
      tries   <= '0;
    end else if (ctrl.bumpTry) begin
      tries <= tries + 1'b1;
    end
  end

  // shared wait timer for pulse and verify settle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer <= '0;
    end else if (ctrl.armPulse) begin
      timer <= TMR_W'(PULSE_CYC - 1);
    end else if (ctrl.armVerify) begin
      timer <= TMR_W'(VERIFY_CYC - 1);
    end else if (timer != '0) begin
      timer <= timer - 1'b1;
    end
  end

  always_comb begin
    stat.timerZero  = (timer == '0);
    stat.lastByte   = (remaining == CNT_W'(1));
    stat.noBytes    = (byteCount == '0);
    stat.triesSpent = (tries == TRY_W'(MAX_TRIES));
    stat.readMatch  = (busRdata == curData);
  end

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       srcValid,
  input  logic       busAck,
  input  dpStat_t    stat,
  input  logic [7:0] curData,
  output dpCtrl_t    ctrl,
  output logic       srcReady,
  output logic       busReq,
  output logic       busWe,
  output logic [7:0] busWdata,
  output logic       hvEnable,
  output logic       done,
  output logic       fail
);

  seqState_t state, nxt;
  logic failFlag, setFail, clrFail;

  always_comb begin
    nxt     = state;
    ctrl    = '0;
    setFail = 1'b0;
    clrFail = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        ctrl.loadStart = 1'b1;
        clrFail        = 1'b1;
        nxt            = stat.noBytes ? S_FINISH : S_FETCH;
      end
      S_FETCH: if (srcValid) begin
        ctrl.loadByte = 1'b1;
        nxt           = S_SETUP;
      end
      S_SETUP: if (busAck) nxt = S_LOAD;
      S_LOAD: if (busAck) begin
        ctrl.armPulse = 1'b1;
        ctrl.bumpTry  = 1'b1;
        nxt           = S_PULSE;
      end
      S_PULSE: if (stat.timerZero) nxt = S_VCMD;
      S_VCMD: if (busAck) begin
        ctrl.armVerify = 1'b1;
        nxt            = S_VWAIT;
      end
      S_VWAIT: if (stat.timerZero) nxt = S_READ;
      S_READ: if (busAck) begin
        if (stat.readMatch) begin
          if (stat.lastByte) begin
            nxt = S_FINISH;
          end else begin
            ctrl.advance = 1'b1;
            nxt          = S_FETCH;
          end
        end else if (stat.triesSpent) begin
          setFail = 1'b1;
          nxt     = S_FINISH;
        end else begin
          nxt = S_SETUP;
        end
      end
      S_FINISH: if (busAck) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      failFlag <= 1'b0;
      done     <= 1'b0;
    end else begin
      state <= nxt;
      done  <= (state == S_FINISH) && busAck;
      if (clrFail)      failFlag <= 1'b0;
      else if (setFail) failFlag <= 1'b1;
    end
  end

  always_comb begin
    busReq   = (state == S_SETUP) || (state == S_LOAD) || (state == S_VCMD) ||
               (state == S_READ)  || (state == S_FINISH);
    busWe    = (state != S_READ);
    srcReady = (state == S_FETCH);
    hvEnable = (state != S_IDLE);
    fail     = failFlag && (state == S_IDLE);
    unique case (state)
      S_SETUP: busWdata = CMD_SETUP;
      S_LOAD:  busWdata = curData;
      S_VCMD:  busWdata = CMD_VERIFY;
      default: busWdata = CMD_READ;
    endcase
  end

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int CNT_W      = ADDR_W + 1,
  parameter int PULSE_CYC  = 1000,
  parameter int VERIFY_CYC = 600,
  parameter int MAX_TRIES  = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic              srcValid,
  input  logic [7:0]        srcData,
  output logic              srcReady,
  output logic              busReq,
  output logic              busWe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busWdata,
  input  logic              busAck,
  input  logic [7:0]        busRdata,
  output logic              hvEnable,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] failAddr
);

  dpCtrl_t           ctrl;
  dpStat_t           stat;
  logic [ADDR_W-1:0] curAddr;
  logic [7:0]        curData;

  flash_prog_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .srcValid(srcValid), .busAck(busAck),
    .stat(stat), .curData(curData), .ctrl(ctrl), .srcReady(srcReady),
    .busReq(busReq), .busWe(busWe), .busWdata(busWdata), .hvEnable(hvEnable),
    .done(done), .fail(fail)
  );

  flash_prog_dpath #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PULSE_CYC(PULSE_CYC),
    .VERIFY_CYC(VERIFY_CYC), .MAX_TRIES(MAX_TRIES)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .startAddr(startAddr), .byteCount(byteCount),
    .srcData(srcData), .busRdata(busRdata), .stat(stat), .curAddr(curAddr),
    .curData(curData)
  );

  assign busAddr  = curAddr;
  assign failAddr = fail ? curAddr : '0;

endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk #(
  parameter int ADDR_W     = 18,
  parameter int PULSE_CYC  = 1000,
  parameter int VERIFY_CYC = 600,
  parameter int MAX_TRIES  = 25
) (
  input logic              clk,
  input logic              rstN,
  input logic              srcValid,
  input logic              srcReady,
  input logic              busReq,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [7:0]        busWdata,
  input logic              busAck,
  input logic              hvEnable,
  input logic              done,
  input logic              fail
);

  localparam int GAP_TOP = (PULSE_CYC > VERIFY_CYC) ? PULSE_CYC : VERIFY_CYC;
  localparam int GAP_W   = $clog2(GAP_TOP + 2);
  localparam int TRY_W   = $clog2(MAX_TRIES + 2);

  logic             afterSetup, prevData;
  logic [GAP_W-1:0] gap;
  logic [TRY_W-1:0] tries;
  logic             wrAck;

  assign wrAck = busReq && busAck && busWe;

  // classify the command stream seen at the bus
  always_ff @(posedge clk) begin
    if (!rstN) begin
      afterSetup <= 1'b0;
      prevData   <= 1'b0;
      gap        <= '0;
      tries      <= '0;
    end else begin
      if (wrAck) begin
        if (afterSetup) begin
          afterSetup <= 1'b0;
          prevData   <= 1'b1;
          gap        <= '0;
        end else if (prevData) begin
          prevData <= 1'b0;
          gap      <= '0;
        end else begin
          afterSetup <= (busWdata == 8'h40);
        end
      end else if (gap != GAP_W'(GAP_TOP)) begin
        gap <= gap + 1'b1;
      end
      if (srcValid && srcReady) begin
        tries <= '0;
      end else if (wrAck && !afterSetup && !prevData && busWdata == 8'h40 &&
                   tries != TRY_W'(MAX_TRIES + 1)) begin
        tries <= tries + 1'b1;
      end
    end
  end

  assert_verify_gap_R3: assert property (@(posedge clk) disable iff (!rstN)
    prevData && busReq |-> gap >= GAP_W'(PULSE_CYC));

  assert_read_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busWe |-> gap >= GAP_W'(VERIFY_CYC));

  assert_try_limit_R6: assert property (@(posedge clk) disable iff (!rstN)
    tries <= TRY_W'(MAX_TRIES));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !hvEnable && !busReq);

  assert_fail_with_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fail) |-> done);

  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busAddr) && $stable(busWdata) && $stable(busWe));

  assert_hv_on_bus_R11: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> hvEnable);

  assert_src_exclusive_R12: assert property (@(posedge clk) disable iff (!rstN)
    srcReady |-> !busReq);

endmodule

bind flash_prog_seq flash_prog_seq_chk #(
  .ADDR_W(ADDR_W), .PULSE_CYC(PULSE_CYC), .VERIFY_CYC(VERIFY_CYC), .MAX_TRIES(MAX_TRIES)
) u_chk (
  .clk(clk), .rstN(rstN), .srcValid(srcValid), .srcReady(srcReady), .busReq(busReq),
  .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata), .busAck(busAck),
  .hvEnable(hvEnable), .done(done), .fail(fail)
);

// File: tb/flash_prog_seq_tb.sv
`timescale 1ns/1ps
module flash_prog_seq_tb;

  localparam int ADDR_W = 18;
  localparam int CNT_W  = ADDR_W + 1;
  localparam int PULSE  = 12;
  localparam int VERIF  = 5;
  localparam int MAXT   = 25;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [CNT_W-1:0]  byteCount = '0;
  logic              srcValid = 1'b0;
  logic [7:0]        srcData = '0;
  logic              srcReady, busReq, busWe, hvEnable, done, fail;
  logic [ADDR_W-1:0] busAddr, failAddr;
  logic [7:0]        busWdata;
  logic              busAck = 1'b0;
  logic [7:0]        busRdata = '0;

  flash_prog_seq #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PULSE_CYC(PULSE), .VERIFY_CYC(VERIF), .MAX_TRIES(MAXT)
  ) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr), .byteCount(byteCount),
    .srcValid(srcValid), .srcData(srcData), .srcReady(srcReady), .busReq(busReq),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata), .busAck(busAck),
    .busRdata(busRdata), .hvEnable(hvEnable), .done(done), .fail(fail), .failAddr(failAddr)
  );

  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;

  // flash model state
  int          need[64];
  int          pulses[64];
  logic [7:0]  fmem[64];
  logic [7:0]  srcBuf[16];
  int          srcPtr = 0, srcCnt = 0;
  int          mmode = 0;          // 0 command, 1 data expected, 2 verify read expected
  int          orderErr = 0, hvViol = 0, rdCmdCnt = 0;
  logic [7:0]  lastWr = 8'hAA;
  int          cyc = 0, reqCyc = 0, dataAckCyc = 0, verAckCyc = 0;
  int          minPGap = 1000000, minVGap = 1000000;
  bit          pend = 1'b0;
  logic [ADDR_W-1:0] runStart = '0;
  int          expIdx = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] expAddr();
    return runStart + ADDR_W'(expIdx);
  endfunction

  // index of the first byte needing more than MAXT pulses, or -1
  function automatic int firstFail(input logic [ADDR_W-1:0] st, input int n);
    for (int i = 0; i < n; i++)
      if (need[(int'(st[5:0]) + i) % 64] > MAXT) return i;
    return -1;
  endfunction

  // source stream and flash model, all driven away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rstN) begin
      busAck   = 1'b0;
      srcValid = 1'b0;
    end else begin
      if (srcReady && srcPtr < srcCnt && ($urandom % 2 == 0)) begin
        srcValid = 1'b1;
        srcData  = srcBuf[srcPtr];
        srcPtr++;
      end else begin
        srcValid = 1'b0;
      end
      busAck = 1'b0;
      if (busReq) begin
        if (!pend) begin pend = 1'b1; reqCyc = cyc; end
        if (!hvEnable) hvViol++;
        if ($urandom % 3 != 0) begin
          int a;
          busAck = 1'b1;
          pend   = 1'b0;
          a      = int'(busAddr[5:0]);
          if (busWe) begin
            lastWr = busWdata;
            if (mmode == 1) begin
              if (busAddr != expAddr()) orderErr++;
              pulses[a]++;
              fmem[a]    = busWdata;
              dataAckCyc = cyc;
              mmode      = 0;
            end else if (busWdata == 8'h40) begin
              mmode = 1;
            end else if (busWdata == 8'hC0) begin
              if (reqCyc - dataAckCyc < minPGap) minPGap = reqCyc - dataAckCyc;
              verAckCyc = cyc;
              mmode     = 2;
            end else if (busWdata == 8'h00) begin
              rdCmdCnt++;
            end else begin
              orderErr++;
            end
          end else begin
            if (mmode != 2 || busAddr != expAddr()) orderErr++;
            if (reqCyc - verAckCyc < minVGap) minVGap = reqCyc - verAckCyc;
            if (pulses[a] >= need[a]) begin
              busRdata = fmem[a];
              expIdx++;
            end else begin
              busRdata = ~fmem[a];
            end
            mmode = 0;
          end
        end
      end
    end
  end

  task automatic runOne(input logic [ADDR_W-1:0] st, input int n, input string tag);
    int  fi;
    bit  got;
    fi = firstFail(st, n);
    for (int i = 0; i < 64; i++) begin pulses[i] = 0; fmem[i] = 8'hFF; end
    for (int i = 0; i < 16; i++) srcBuf[i] = 8'($urandom);
    srcCnt = n; srcPtr = 0; mmode = 0; orderErr = 0; hvViol = 0; rdCmdCnt = 0;
    minPGap = 1000000; minVGap = 1000000; runStart = st; expIdx = 0; lastWr = 8'hAA;
    @(negedge clk);
    start = 1'b1; startAddr = st; byteCount = CNT_W'(n);
    @(negedge clk);
    start = 1'b0;
    got = 1'b0;
    for (int k = 0; k < 30000; k++) begin
      if (done) begin got = 1'b1; break; end
      @(negedge clk);
    end
    chk(got, {"R8 done ", tag}, got, 1);
    chk(fail == (fi >= 0), {"R6 fail flag ", tag}, fail, fi >= 0);
    chk(failAddr == ((fi >= 0) ? st + ADDR_W'(fi) : '0), {"R9 failAddr ", tag},
        failAddr, (fi >= 0) ? st + ADDR_W'(fi) : '0);
    chk(!hvEnable, {"R8 hv released ", tag}, hvEnable, 0);
    chk(rdCmdCnt == 1 && lastWr == 8'h00, {"R8 read command last ", tag}, lastWr, 0);
    chk(orderErr == 0, {"R2 R7 order and address ", tag}, orderErr, 0);
    chk(hvViol == 0, {"R11 hv during bus ", tag}, hvViol, 0);
    if (n > 0) begin
      chk(minPGap >= PULSE, {"R3 pulse wait ", tag}, minPGap, PULSE);
      chk(minVGap >= VERIF, {"R4 verify wait ", tag}, minVGap, VERIF);
    end
    for (int i = 0; i < n; i++) begin
      int a, ep;
      a  = (int'(st[5:0]) + i) % 64;
      ep = (fi < 0 || i < fi) ? need[a] : (i == fi ? MAXT : 0);
      chk(pulses[a] == ep, {"R5 R6 pulse count ", tag}, pulses[a], ep);
      if (fi < 0 || i < fi)
        chk(fmem[a] == srcBuf[i], {"R7 stored byte ", tag}, fmem[a], srcBuf[i]);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h1234_5eed));
    for (int i = 0; i < 64; i++) need[i] = 1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!hvEnable && !busReq, "R1 idle bus/hv after reset", {hvEnable, busReq}, 0);
    chk(!srcReady && !done && !fail, "R1 idle flags after reset", {srcReady, done, fail}, 0);

    // R10 empty run
    runOne(ADDR_W'(5), 0, "zero-count R10");
    for (int i = 0; i < 64; i++) chk(pulses[i] == 0, "R10 no pulses", pulses[i], 0);

    // random passing runs
    for (int r = 0; r < 6; r++) begin
      logic [ADDR_W-1:0] st;
      int n;
      st = {ADDR_W-6'($urandom), 6'($urandom % 41)};
      n  = 1 + int'($urandom % 8);
      for (int i = 0; i < 64; i++) need[i] = 1 + int'($urandom % 4);
      runOne(st, n, "random pass");
    end

    // boundary: a byte needing exactly the limit still passes (R5)
    for (int i = 0; i < 64; i++) need[i] = 1;
    need[11] = MAXT;
    runOne(ADDR_W'(10), 3, "limit pass R5");

    // failure in the middle of a run (R6, R9)
    for (int i = 0; i < 64; i++) need[i] = 2;
    need[22] = MAXT + 1;
    runOne(ADDR_W'(20) | ADDR_W'(18'h2_0000), 4, "mid fail R6");

    // next start clears the failure (R9)
    for (int i = 0; i < 64; i++) need[i] = 1 + int'($urandom % 3);
    runOne(ADDR_W'(40), 5, "pass after fail R9");

    // failure on the only byte
    need[33] = 99;
    runOne(ADDR_W'(33), 1, "single fail R6");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule